// File: doc/BRIEF.md
# Data Breakpoint Address Matcher

The block holds a parameterised set of data watch units. Each unit has a base address register and a control register. The control register sets whether stores, loads or both should trigger, and it holds a small mask that selects which low address bits take part in the compare. Every memory access that the pipeline presents is checked against all units in the same cycle. The per-unit hit vector is available early enough for the core to stop the access before it takes effect. This block only detects the hit. Raising the debug exception belongs to the core.

Each mask is made contiguous when it is written. A mask with holes is cut at its first zero, counted from the most significant mask bit. The watched range is always an aligned power-of-two block of bytes.

Top module: `dbw_match`

## Requirements
- R1: After reset every unit is inactive, and `hit_o` is all zeros for every access until the registers are written.
- R2: Control register bit 31 enables store triggering, so accesses with `acc_write_i`=1 can match. Bit 30 enables load triggering, so accesses with `acc_write_i`=0 can match. An access whose type is not enabled never hits.
- R3: A unit with both bit 31 and bit 30 clear never hits, whatever the address.
- R4: The mask field is control bits [5:0]. A 1 in the field means that address bit is compared. Address bits 6 and above are always compared. For a contiguous field with z trailing zeros, the unit watches the aligned 2^z-byte block that contains the base address. All ones gives a single byte; all zeros gives 64 bytes.
- R5: A field with holes is replaced by its run of leading ones, counted down from bit 5. For example, 110101 acts as 110000 and covers 16 bytes, and 011111 acts as 000000 and covers 64 bytes.
- R6: `hit_o` is combinational in the access: it is valid in the same cycle as `acc_valid_i`, and it is all zeros while `acc_valid_i` is low.
- R7: A write with `wr_en_i`=1 goes to unit `wr_sel_i`. It goes to the address register when `wr_ctl_i`=0 and to the control register when `wr_ctl_i`=1. It takes effect from the next cycle, so an access in the same cycle uses the old value. Other units are not changed.
- R8: Each unit reports on its own bit `hit_o[i]`, so several units can hit on one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | SEL_W | Unit index for the write |
| wr_ctl_i | input | 1 | 1: control register, 0: address register |
| wr_data_i | input | ADDR_W | Register write data |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | ADDR_W | Access byte address |
| acc_write_i | input | 1 | 1: store, 0: load |
| hit_o | output | N_UNITS | Per-unit match |

## Verification
A hit is due in the same cycle as the access, with no register in the path. A register write takes effect one rising edge later. The bench drives every input just after the falling edge. It compares `hit_o` against a behavioural range model a few nanoseconds later, before the next rising edge. It applies any write to the model only after that rising edge, so each comparison uses the register contents the design holds in that cycle. Directed cases cover type gating, all-ones and all-zeros masks, and masks with holes. They also cover a write and an access in the same cycle, and units that overlap. A random phase follows the directed cases.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
  localparam int unsigned CTL_ST_BIT = 31;
  localparam int unsigned CTL_LD_BIT = 30;

  typedef enum logic {
    REG_BASE = 1'b0,
    REG_CTL  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dbw_mask_norm.sv
// Keeps only the leading run of ones of the mask field.
module dbw_mask_norm #(
  parameter int unsigned MASK_W = 6
) (
  input  logic [MASK_W-1:0] field_i,
  output logic [MASK_W-1:0] norm_o
);
  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    assign norm_o[i] = &field_i[MASK_W-1:i];
  end
endmodule

// File: rtl/dbw_unit.sv
module dbw_unit
  import dbw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_base_i,
  input  logic              wr_ctl_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] base_q;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              st_en_q, ld_en_q;
  logic              hi_eq, lo_eq, type_ok;
  logic [MASK_W-1:0] lo_diff;

  dbw_mask_norm #(.MASK_W(MASK_W)) u_norm (
    .field_i (wr_data_i[MASK_W-1:0]),
    .norm_o  (mask_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      mask_q  <= '0;
      st_en_q <= 1'b0;
      ld_en_q <= 1'b0;
    end else begin
      if (wr_base_i) base_q <= wr_data_i;
      if (wr_ctl_i) begin
        mask_q  <= mask_d;
        st_en_q <= wr_data_i[CTL_ST_BIT];
        ld_en_q <= wr_data_i[CTL_LD_BIT];
      end
    end
  end

  assign hi_eq   = (acc_addr_i[ADDR_W-1:MASK_W] == base_q[ADDR_W-1:MASK_W]);
  assign lo_diff = (acc_addr_i[MASK_W-1:0] ^ base_q[MASK_W-1:0]) & mask_q;
  assign lo_eq   = (lo_diff == '0);
  assign type_ok = acc_write_i ? st_en_q : ld_en_q;
  assign hit_o   = acc_valid_i & type_ok & hi_eq & lo_eq;

  // R3
  a_r3_idle_unit_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_en_q && !ld_en_q) |-> !hit_o);
  // R2
  a_r2_store_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && acc_write_i) |-> st_en_q);
  a_r2_load_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !acc_write_i) |-> ld_en_q);
  // R5: stored mask has no holes
  a_r5_mask_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((~mask_q) + MASK_W'(1)) & (~mask_q)) == '0);
  // R7
  a_r7_ctl_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl_i |=> (st_en_q == $past(wr_data_i[CTL_ST_BIT])) &&
                 (ld_en_q == $past(wr_data_i[CTL_LD_BIT])));
  a_r7_base_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_base_i |=> $stable(base_q));
endmodule

// File: rtl/dbw_match.sv
module dbw_match
  import dbw_pkg::*;
#(
  parameter int unsigned N_UNITS = 2,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned MASK_W  = 6,
  localparam int unsigned SEL_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic               wr_ctl_i,
  input  logic [ADDR_W-1:0]  wr_data_i,
  input  logic               acc_valid_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic               acc_write_i,
  output logic [N_UNITS-1:0] hit_o
);
  reg_sel_e reg_sel;
  assign reg_sel = reg_sel_e'(wr_ctl_i);

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    logic sel_hit;
    assign sel_hit = wr_en_i && (wr_sel_i == SEL_W'(g));

    dbw_unit #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_unit (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_base_i   (sel_hit && (reg_sel == REG_BASE)),
      .wr_ctl_i    (sel_hit && (reg_sel == REG_CTL)),
      .wr_data_i   (wr_data_i),
      .acc_valid_i (acc_valid_i),
      .acc_addr_i  (acc_addr_i),
      .acc_write_i (acc_write_i),
      .hit_o       (hit_o[g])
    );
  end

  // R6
  a_r6_no_access_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (hit_o == '0));
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (hit_o == '0));
endmodule

// File: tb/dbw_match_tb.sv
`timescale 1ns/1ps
module dbw_match_tb;
  localparam int N = 2;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [0:0]  wr_sel_i = '0;
  logic        wr_ctl_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic        acc_write_i = 1'b0;
  logic [N-1:0] hit_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] m_base [N];
  logic [31:0] m_ctl  [N];

  always #10 clk_i = ~clk_i;

  dbw_match u_dut (.*);

  function automatic logic [N-1:0] model_hit(logic v, logic [31:0] a, logic w);
    logic [N-1:0] r = '0;
    for (int u = 0; u < N; u++) begin
      int k = 0;
      longint size, lo;
      logic en;
      for (int b = 5; b >= 0; b--) begin
        if (m_ctl[u][b]) k++;
        else break;
      end
      size = 64'(1) << (6 - k);
      lo = longint'(m_base[u]) - (longint'(m_base[u]) % size);
      en = w ? m_ctl[u][31] : m_ctl[u][30];
      r[u] = v && en && (longint'(a) >= lo) && (longint'(a) < lo + size);
    end
    return r;
  endfunction

  task automatic step(input string tag, input logic we, input logic sel,
                      input logic ctl, input logic [31:0] d,
                      input logic v, input logic [31:0] a, input logic w);
    logic [N-1:0] exp;
    @(negedge clk_i);
    wr_en_i = we; wr_sel_i = sel; wr_ctl_i = ctl; wr_data_i = d;
    acc_valid_i = v; acc_addr_i = a; acc_write_i = w;
    #3;
    exp = rst_ni ? model_hit(v, a, w) : '0;
    checks++;
    if (hit_o !== exp) begin
      fails++;
      $display("FAIL %s: addr=%h wr=%0d hit=%b expected=%b", tag, a, w, hit_o, exp);
    end
    @(posedge clk_i);
    #1;
    if (rst_ni && we) begin
      if (ctl) m_ctl[sel] = d;
      else     m_base[sel] = d;
    end
  endtask

  task automatic acc(input string tag, input logic [31:0] a, input logic w);
    step(tag, 0, 0, 0, 0, 1, a, w);
  endtask

  task automatic wr(input logic sel, input logic ctl, input logic [31:0] d);
    step("R7", 1, sel, ctl, d, 0, 0, 0);
  endtask

  initial begin
    for (int u = 0; u < N; u++) begin m_base[u] = '0; m_ctl[u] = '0; end
    step("R1", 0, 0, 0, 0, 1, 32'h0, 1);
    #15 rst_ni = 1'b1;
    acc("R1", 32'h0, 1);
    acc("R1", 32'h0, 0);

    // single byte, store only
    wr(0, 0, 32'h1000_0040);
    wr(0, 1, 32'h8000_003F);
    acc("R2", 32'h1000_0040, 1);
    acc("R2", 32'h1000_0040, 0);
    acc("R4", 32'h1000_0041, 1);
    acc("R4", 32'h2000_0040, 1);
    // 64 bytes, load only
    wr(0, 1, 32'h4000_0000);
    acc("R4", 32'h1000_007F, 0);
    acc("R4", 32'h1000_0040, 0);
    acc("R4", 32'h1000_0080, 0);
    acc("R2", 32'h1000_0050, 1);
    // 4-byte region on unit 1
    wr(1, 0, 32'h2000_0013);
    wr(1, 1, 32'hC000_003C);
    for (int i = 'h0F; i <= 'h14; i++) acc("R4", 32'h2000_0000 | i, i[0]);
    // hole in mask: 110101 -> 16 bytes
    wr(1, 1, 32'hC000_0035);
    acc("R5", 32'h2000_0018, 0);
    acc("R5", 32'h2000_001F, 1);
    acc("R5", 32'h2000_0020, 1);
    acc("R5", 32'h2000_000F, 0);
    // 011111 -> 64 bytes
    wr(1, 1, 32'hC000_001F);
    acc("R5", 32'h2000_0000, 1);
    acc("R5", 32'h2000_003F, 0);
    // inactive unit
    wr(1, 1, 32'h0000_003F);
    acc("R3", 32'h2000_0013, 1);
    acc("R3", 32'h2000_0013, 0);
    // no access strobe
    wr(1, 1, 32'hC000_003F);
    step("R6", 0, 0, 0, 0, 0, 32'h2000_0013, 1);
    acc("R6", 32'h2000_0013, 1);
    // write and access same cycle: old value used
    step("R7", 1, 1, 0, 32'h3000_0000, 1, 32'h2000_0013, 0);
    acc("R7", 32'h2000_0013, 0);
    acc("R7", 32'h3000_0000, 0);
    acc("R7", 32'h1000_0050, 0);
    // overlapping units
    wr(1, 0, 32'h1000_0055);
    wr(1, 1, 32'hC000_0030);
    acc("R8", 32'h1000_005A, 0);
    acc("R8", 32'h1000_0045, 0);
    acc("R8", 32'h1000_0045, 1);
    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom_range(0, 3) == 0) begin
        logic c;
        c = 1'($urandom);
        if (!c) d = {24'h0, 8'(d)};
        step("R7", 1, 1'($urandom), c, d, 1'($urandom), {24'h0, 8'($urandom)}, 1'($urandom));
      end else begin
        step("R4", 0, 0, 0, 0, 1'($urandom), {24'h0, 8'($urandom)}, 1'($urandom));
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule